// File: doc/BRIEF.md
# Framed Multichannel Serial Output Port

This block is a master-mode serial transmitter for a three-phase measurement front end. Each time the converters signal that a fresh result set is ready, the port takes a snapshot of six 16-bit two's complement samples. There is one voltage word and one current word for each of three phases. The port then sends the snapshot as one frame on three outputs that it generates itself: a gated serial clock, a frame-sync pulse and serial data.

A frame starts with a frame-sync pulse that lasts one serial-clock period, with the serial clock held low. After that pulse come exactly 96 serial-clock periods that carry the six words. The serial clock runs at one eighth or one quarter of the master clock, chosen by a rate-select input. The clock stays low whenever no frame is in progress. Each of the three outputs has an output-enable signal that follows a single enable input, so a pad ring can float the port.

The snapshot is taken into a shadow shift register when the ready strobe arrives. After that point, changes at the sample inputs, at the rate select, or a further strobe do not alter the frame in progress.

Top module: `framed_serial_tx`

## Requirements
- R1: The serial clock period is 8 master-clock cycles when `rateSel` is 0 and 4 cycles when it is 1. Within each period the serial clock is low for the first half and high for the second half.
- R2: The serial clock is low whenever no data bit is being sent, including after reset and between frames.
- R3: On the master-clock edge that samples `sampleReady` high while the port is idle, frame sync rises. It stays high for exactly one serial-clock period, and the serial clock stays low for that whole period.
- R4: Frame sync falls at the end of that period. The serial clock then completes exactly 96 periods and returns to low.
- R5: Words leave in the order phase-1 voltage, phase-1 current, phase-2 voltage, phase-2 current, phase-3 voltage, phase-3 current. Phase p (0-based) occupies bits [16p+15:16p] of `voltWords` and `currWords`.
- R6: Each word is sent most significant bit first. Serial data changes only where the serial clock falls, or at the start of the first period, so it is stable while the clock is high.
- R7: `sclkOe`, `fsyncOe` and `sdataOe` equal `outEn` at all times. A low value means that the matching output is to be high impedance.
- R8: While `rstN` is low, the serial clock, frame sync and serial data are 0, and the port becomes idle.
- R9: The six words are captured on the starting strobe. A later change of `voltWords` or `currWords`, or a `sampleReady` pulse during a frame, has no effect on the frame in progress. A strobe that arrives during a frame does not start a frame afterwards.
- R10: Serial data is 0 whenever no bit is being sent.
- R11: The rate is taken from `rateSel` on the starting strobe. A change of `rateSel` during a frame does not change that frame's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rateSel | input | 1 | 0: serial clock = clk/8, 1: serial clock = clk/4 |
| outEn | input | 1 | Drive enable for the three serial outputs |
| sampleReady | input | 1 | One-cycle strobe: a new result set is on the word inputs |
| voltWords | input | 48 | Voltage words, phase p at bits [16p+15:16p] |
| currWords | input | 48 | Current words, phase p at bits [16p+15:16p] |
| sclkOut | output | 1 | Gated serial clock |
| fsyncOut | output | 1 | Frame-sync pulse |
| sdataOut | output | 1 | Serial data, MSB first |
| sclkOe | output | 1 | Output enable for sclkOut |
| fsyncOe | output | 1 | Output enable for fsyncOut |
| sdataOe | output | 1 | Output enable for sdataOut |

## Verification
The bench builds the port with its default parameters: 16-bit words, three phases, and divisors of 8 and 4. With these values one frame is 97 serial periods, so a whole frame at either rate takes fewer than 800 master cycles. This means every bit position of all six words, including the word boundaries and the last-bit return to idle, can be compared cycle by cycle at both rates within the run. Random words, mid-frame strobes, mid-frame rate changes and a reset during a frame are all exercised against the same timing model.

// File: rtl/framed_serial_tx_pkg.sv
package framed_serial_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYNC = 2'd1,
    ST_DATA = 2'd2
  } txState_t;

  // Strobes from the sequencer to the output datapath
  typedef struct packed {
    logic load;        // capture the six words into the shadow register
    logic shift;       // advance to the next bit (at a serial clock fall)
    logic dataActive;  // a data bit is on the line this cycle
    logic sclkLevel;   // serial clock level this cycle
    logic fsyncLevel;  // frame-sync level this cycle
  } txStrobes_t;

endpackage

// File: rtl/framed_serial_tx_ctrl.sv
module framed_serial_tx_ctrl
  import framed_serial_tx_pkg::*;
#(
  parameter int SLOW_DIV   = 8,
  parameter int FAST_DIV   = 4,
  parameter int TOTAL_BITS = 96
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rateSel,
  input  logic       sampleReady,
  output txStrobes_t strobes
);

  localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int DIV_W   = $clog2(MAX_DIV);
  localparam int BIT_W   = $clog2(TOTAL_BITS);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(TOTAL_BITS - 1);
  localparam logic [DIV_W-1:0] SLOW_LAST = DIV_W'(SLOW_DIV - 1);
  localparam logic [DIV_W-1:0] FAST_LAST = DIV_W'(FAST_DIV - 1);
  localparam logic [DIV_W-1:0] SLOW_HALF = DIV_W'(SLOW_DIV / 2);
  localparam logic [DIV_W-1:0] FAST_HALF = DIV_W'(FAST_DIV / 2);

  txState_t         state;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLast;
  logic [DIV_W-1:0] halfPt;
  logic [BIT_W-1:0] bitCnt;
  logic             periodEnd;

  assign periodEnd = (divCnt == divLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      bitCnt  <= '0;
      divLast <= SLOW_LAST;
      halfPt  <= SLOW_HALF;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (sampleReady) begin
            state   <= ST_SYNC;
            divCnt  <= '0;
            divLast <= rateSel ? FAST_LAST : SLOW_LAST;
            halfPt  <= rateSel ? FAST_HALF : SLOW_HALF;
          end
        end
        ST_SYNC: begin
          if (periodEnd) begin
            divCnt <= '0;
            bitCnt <= '0;
            state  <= ST_DATA;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (periodEnd) begin
            divCnt <= '0;
            if (bitCnt == LAST_BIT) begin
              state <= ST_IDLE;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes            = '0;
    strobes.load       = (state == ST_IDLE) && sampleReady;
    strobes.dataActive = (state == ST_DATA);
    strobes.shift      = (state == ST_DATA) && periodEnd && (bitCnt != LAST_BIT);
    strobes.sclkLevel  = (state == ST_DATA) && (divCnt >= halfPt);
    strobes.fsyncLevel = (state == ST_SYNC);
  end

  AST_FRAME_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobes.fsyncLevel) |-> $past(sampleReady)) else $error("frame sync without strobe"); // R3
  AST_BIT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST_BIT) else $error("bit counter past frame end"); // R4
  AST_NO_RELOAD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> !strobes.load) else $error("reload during frame"); // R9
  AST_SYNC_TO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobes.fsyncLevel) |-> (state == ST_DATA) && (bitCnt == '0)) else $error("bad sync exit"); // R4

endmodule

// File: rtl/framed_serial_tx_dp.sv
module framed_serial_tx_dp
  import framed_serial_tx_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int PHASES = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  txStrobes_t                 strobes,
  input  logic [PHASES*WORD_W-1:0]   voltWords,
  input  logic [PHASES*WORD_W-1:0]   currWords,
  output logic                       sclkOut,
  output logic                       fsyncOut,
  output logic                       sdataOut
);

  localparam int TOTAL_BITS = 2 * PHASES * WORD_W;

  logic [TOTAL_BITS-1:0] frameImage;
  logic [TOTAL_BITS-1:0] shadowReg;

  // Lay out the frame: for each phase, voltage word then current word
  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    assign frameImage[TOTAL_BITS-1-(2*p)*WORD_W   -: WORD_W] = voltWords[p*WORD_W +: WORD_W];
    assign frameImage[TOTAL_BITS-1-(2*p+1)*WORD_W -: WORD_W] = currWords[p*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowReg <= '0;
    end else if (strobes.load) begin
      shadowReg <= frameImage;
    end else if (strobes.shift) begin
      shadowReg <= {shadowReg[TOTAL_BITS-2:0], 1'b0};
    end
  end

  assign sdataOut = strobes.dataActive & shadowReg[TOTAL_BITS-1];
  assign sclkOut  = strobes.sclkLevel;
  assign fsyncOut = strobes.fsyncLevel;

  AST_LOAD_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> shadowReg[TOTAL_BITS-1 -: WORD_W] == $past(voltWords[WORD_W-1:0]))
    else $error("first word is not phase-1 voltage"); // R5
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.shift) |=> $stable(shadowReg))
    else $error("shadow changed without strobe"); // R9

endmodule

// File: rtl/framed_serial_tx.sv
module framed_serial_tx
  import framed_serial_tx_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int PHASES   = 3,
  parameter int SLOW_DIV = 8,
  parameter int FAST_DIV = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     rateSel,
  input  logic                     outEn,
  input  logic                     sampleReady,
  input  logic [PHASES*WORD_W-1:0] voltWords,
  input  logic [PHASES*WORD_W-1:0] currWords,
  output logic                     sclkOut,
  output logic                     fsyncOut,
  output logic                     sdataOut,
  output logic                     sclkOe,
  output logic                     fsyncOe,
  output logic                     sdataOe
);

  localparam int TOTAL_BITS = 2 * PHASES * WORD_W;

  txStrobes_t strobes;

  framed_serial_tx_ctrl #(
    .SLOW_DIV  (SLOW_DIV),
    .FAST_DIV  (FAST_DIV),
    .TOTAL_BITS(TOTAL_BITS)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .rateSel    (rateSel),
    .sampleReady(sampleReady),
    .strobes    (strobes)
  );

  framed_serial_tx_dp #(
    .WORD_W(WORD_W),
    .PHASES(PHASES)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .voltWords(voltWords),
    .currWords(currWords),
    .sclkOut  (sclkOut),
    .fsyncOut (fsyncOut),
    .sdataOut (sdataOut)
  );

  assign sclkOe  = outEn;
  assign fsyncOe = outEn;
  assign sdataOe = outEn;

  AST_SDATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sclkOut && $past(sclkOut)) |-> $stable(sdataOut)) else $error("data moved while clock high"); // R6
  AST_FSYNC_NO_SCLK: assert property (@(posedge clk) disable iff (!rstN)
    fsyncOut |-> !sclkOut) else $error("clock toggled during frame sync"); // R3
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    fsyncOut |-> !sdataOut) else $error("data driven during frame sync"); // R10

endmodule

// File: tb/framed_serial_tx_tb_top.sv
`timescale 1ns/1ps
module framed_serial_tx_tb_top;

  localparam int W = 16;
  localparam int P = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rateSel = 1'b0;
  logic outEn = 1'b0;
  logic sampleReady = 1'b0;
  logic [P*W-1:0] voltWords = '0;
  logic [P*W-1:0] currWords = '0;
  logic sclkOut, fsyncOut, sdataOut, sclkOe, fsyncOe, sdataOe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [W-1:0] expV [P];
  logic [W-1:0] expI [P];

  always #10 clk = ~clk;

  framed_serial_tx dut_i (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .outEn(outEn),
    .sampleReady(sampleReady), .voltWords(voltWords), .currWords(currWords),
    .sclkOut(sclkOut), .fsyncOut(fsyncOut), .sdataOut(sdataOut),
    .sclkOe(sclkOe), .fsyncOe(fsyncOe), .sdataOe(sdataOe)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Bit b (0..95) of the frame: word order V1 I1 V2 I2 V3 I3, MSB first
  function automatic logic frameBit(input int b);
    int w = b / W;
    int idx = W - 1 - (b % W);
    logic [W-1:0] word = (w % 2 == 0) ? expV[w/2] : expI[w/2];
    return word[idx];
  endfunction

  function automatic logic [W-1:0] pick(input int n);
    case (n)
      0: return 16'h7FFF;
      1: return 16'h8000;
      2: return 16'h0001;
      3: return 16'hFFFF;
      default: return 16'($urandom);
    endcase
  endfunction

  // One frame; injectAt>=0 pulses sampleReady mid-frame, rstAt>=0 resets mid-frame
  task automatic runFrame(input logic rate, input int pattern, input int injectAt, input int rstAt);
    int div = rate ? 4 : 8;
    int total = 99 * div;
    int rises = 0;
    logic prevSclk = 1'b0;
    @(negedge clk);
    rateSel = rate;
    for (int p = 0; p < P; p++) begin
      expV[p] = pick(pattern == 1 ? p : 9);
      expI[p] = pick(pattern == 1 ? p + 1 : 9);
      voltWords[p*W +: W] = expV[p];
      currWords[p*W +: W] = expI[p];
    end
    sampleReady = 1'b1;
    for (int m = 0; m < total; m++) begin
      logic eF, eC, eD;
      @(negedge clk);
      if (rstAt >= 0 && m == rstAt) begin
        rstN = 1'b0;
        #1;
        check("R8 sclk in reset", sclkOut, 0);
        check("R8 fsync in reset", fsyncOut, 0);
        check("R8 sdata in reset", sdataOut, 0);
        sampleReady = 1'b0;
        @(negedge clk);
        rstN = 1'b1;
        for (int k = 0; k < 20; k++) begin
          @(negedge clk);
          check("R2 sclk idle after reset", sclkOut, 0);
          check("R8 fsync idle after reset", fsyncOut, 0);
          check("R10 sdata idle after reset", sdataOut, 0);
        end
        return;
      end
      eF = 0; eC = 0; eD = 0;
      if (m < div) begin
        eF = 1;
      end else if (m < 97 * div) begin
        int d = m - div;
        eC = ((d % div) >= div / 2);
        eD = frameBit(d / div);
      end
      check(m < div ? "R3 fsync high one period" : "R4 fsync low", fsyncOut, eF);
      check(m < div ? "R3 sclk low during sync" : (m < 97*div ? "R1 sclk waveform" : "R2 sclk idle"), sclkOut, eC);
      check(m < 97*div && m >= div ? "R5 R6 data bit" : "R10 data idle", sdataOut, eD);
      if (sclkOut && !prevSclk) rises++;
      prevSclk = sclkOut;
      // disturb inputs after capture
      if (m == 0) sampleReady = 1'b0;
      voltWords = {P*W/16{16'($urandom)}};
      currWords = {P*W/16{16'($urandom)}};
      if (m == div + 5) rateSel = ~rate;        // R11 mid-frame rate change
      if (m == injectAt) sampleReady = 1'b1;    // R9 mid-frame strobe
      if (m == injectAt + 1) sampleReady = 1'b0;
    end
    check("R4 sclk rising edges per frame", rises, 96);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    check("R8 reset sclk", sclkOut, 0);
    check("R8 reset fsync", fsyncOut, 0);
    check("R8 reset sdata", sdataOut, 0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check("R2 idle sclk", sclkOut, 0);

    // R7 enables follow outEn
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      outEn = 1'($urandom);
      #1;
      check("R7 sclkOe", sclkOe, outEn);
      check("R7 fsyncOe", fsyncOe, outEn);
      check("R7 sdataOe", sdataOe, outEn);
    end
    outEn = 1'b1;

    runFrame(1'b0, 1, -1, -1);   // slow rate, corner words
    runFrame(1'b1, 1, -1, -1);   // fast rate, corner words
    runFrame(1'b0, 0, 300, -1);  // slow, random words, strobe mid-frame
    runFrame(1'b1, 0, 150, -1);  // fast, strobe mid-frame
    runFrame(1'b1, 0, -1, 200);  // reset mid-frame
    runFrame(1'b0, 0, -1, -1);   // normal frame after reset
    for (int k = 0; k < 4; k++) runFrame(1'($urandom), 0, -1, -1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20ns * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule